// File: doc/BRIEF.md
# Dual-Mode Bus Driver with Split Capture

This block drives a 12-bit data word onto a wide output bus, taking it from one of two sources. In buffer mode every input bit flows combinationally to the outputs, with no clock in the path. In register mode the outputs show the contents of a bank of edge-triggered registers. A mode input selects between the two and takes effect at once, without waiting for a clock edge.

The register bank is split into two groups. The upper group (bits at index 8 to 11) loads on every rising clock edge. The lower group (index 0 to 7) loads only when the active-low capture enable is asserted, and holds otherwise. This lets a system refresh a small tag or control field every cycle while freezing the bulk of the word. Every data bit is fanned out to two identical copies, and one active-low output enable releases all copies together. Tristate is modelled as a drive flag together with data that is forced to zero while the bus is released. The output enable never touches the register contents.

Top module: `dual_mode_bus_driver`

## Requirements
- R1: A synchronous active-high reset, sampled on a rising clock edge, clears all register bits to zero. Reset takes priority over any capture in the same cycle.
- R2: When `cap_en_n` is 0 on a rising edge, all register bits load `din`. In register mode (`mode_buf` = 0), the new value appears on the outputs after that edge.
- R3: When `cap_en_n` is 1 on a rising edge, register bits at index 8 to 11 load `din`, and bits at index 0 to 7 keep their previous value.
- R4: When `mode_buf` = 1 and the outputs are enabled, every copy equals `din` combinationally, without any clock edge.
- R5: A change of `mode_buf` switches the outputs between `din` and the register contents within the same cycle. The registers load on every edge in either mode, as R2 and R3 describe.
- R6: `dout` holds two copies of the 12-bit word. Copy 0 is `dout[11:0]` and copy 1 is `dout[23:12]`. Both copies are always identical.
- R7: When `out_en_n` = 1, `dout_drive` is 0 and `dout` is all zeros. When `out_en_n` = 0, `dout_drive` is 1. The output enable has no effect on the register contents: they are visible unchanged once the outputs are enabled again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the register bank |
| rst | input | 1 | Synchronous active-high reset of the register bank |
| mode_buf | input | 1 | 1 = buffer path (combinational), 0 = register path |
| cap_en_n | input | 1 | Active-low capture enable for the lower 8 bits |
| out_en_n | input | 1 | Active-low output enable for all copies |
| din | input | 12 | Data input word |
| dout | output | 24 | Two identical copies of the selected word; copy 0 in the low 12 bits |
| dout_drive | output | 1 | 1 while the outputs drive the bus, 0 while released |

## Verification
Register mode is exercised with all-ones, all-zeros and alternating patterns under full capture. These show whether every bit position loads and whether the two copies track each other. The same patterns are then applied with the capture enable released, which separates the upper group, which must follow the input, from the lower group, which must hold. Buffer mode and mode switching are tested by changing the input and the mode in the middle of a cycle, which tells a combinational path apart from one that waits for a clock. A stretch with the outputs released, while the registers keep capturing, shows that the output enable blanks the bus and leaves the stored word untouched. A reset applied while capture is asserted, with non-zero data, confirms that reset wins.

// File: rtl/bd_pkg.sv
package bd_pkg;
  typedef enum logic {
    PATH_REG = 1'b0,
    PATH_BUF = 1'b1
  } path_sel_e;
endpackage

// File: rtl/bd_capture_reg.sv
module bd_capture_reg #(
  parameter int WIDTH     = 12,
  parameter int HOLD_BITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int FREE_BITS = WIDTH - HOLD_BITS;

  generate
    if (HOLD_BITS > 0) begin : g_hold
      // lower group: loads only while the capture enable is asserted
      always_ff @(posedge clk) begin
        if (rst)
          q[HOLD_BITS-1:0] <= '0;
        else if (!cap_en_n)
          q[HOLD_BITS-1:0] <= d[HOLD_BITS-1:0];
      end
    end
    if (FREE_BITS > 0) begin : g_free
      // upper group: loads on every edge
      always_ff @(posedge clk) begin
        if (rst)
          q[WIDTH-1:HOLD_BITS] <= '0;
        else
          q[WIDTH-1:HOLD_BITS] <= d[WIDTH-1:HOLD_BITS];
      end
    end
  endgenerate
endmodule

// File: rtl/bd_path_mux.sv
module bd_path_mux
  import bd_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  path_sel_e        sel,
  input  logic [WIDTH-1:0] buf_d,
  input  logic [WIDTH-1:0] reg_q,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    unique case (sel)
      PATH_BUF: y = buf_d;
      default:  y = reg_q;
    endcase
  end
endmodule

// File: rtl/bd_fanout.sv
module bd_fanout #(
  parameter int WIDTH  = 12,
  parameter int COPIES = 2
) (
  input  logic                    out_en_n,
  input  logic [WIDTH-1:0]        word,
  output logic [COPIES*WIDTH-1:0] dout,
  output logic                    drive
);
  assign drive = ~out_en_n;

  generate
    for (genvar c = 0; c < COPIES; c++) begin : g_copy
      assign dout[c*WIDTH +: WIDTH] = out_en_n ? '0 : word;
    end
  endgenerate
endmodule

// File: rtl/dual_mode_bus_driver.sv
module dual_mode_bus_driver
  import bd_pkg::*;
#(
  parameter int WIDTH     = 12,
  parameter int HOLD_BITS = 8,
  parameter int COPIES    = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mode_buf,
  input  logic                    cap_en_n,
  input  logic                    out_en_n,
  input  logic [WIDTH-1:0]        din,
  output logic [COPIES*WIDTH-1:0] dout,
  output logic                    dout_drive
);
  localparam int OUT_W = COPIES * WIDTH;

  logic [WIDTH-1:0] reg_q;
  logic [WIDTH-1:0] sel_word;
  logic [OUT_W-1:0] fan_out;
  logic             fan_drive;
  path_sel_e        path;

  assign path = path_sel_e'(mode_buf);

  bd_capture_reg #(.WIDTH(WIDTH), .HOLD_BITS(HOLD_BITS)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .cap_en_n (cap_en_n),
    .d        (din),
    .q        (reg_q)
  );

  bd_path_mux #(.WIDTH(WIDTH)) u_mux (
    .sel   (path),
    .buf_d (din),
    .reg_q (reg_q),
    .y     (sel_word)
  );

  bd_fanout #(.WIDTH(WIDTH), .COPIES(COPIES)) u_fan (
    .out_en_n (out_en_n),
    .word     (sel_word),
    .dout     (fan_out),
    .drive    (fan_drive)
  );

  assign dout       = fan_out;
  assign dout_drive = fan_drive;
endmodule

// File: rtl/bd_driver_checker.sv
module bd_driver_checker #(
  parameter int WIDTH     = 12,
  parameter int HOLD_BITS = 8,
  parameter int COPIES    = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    mode_buf,
  input logic                    cap_en_n,
  input logic                    out_en_n,
  input logic [WIDTH-1:0]        din,
  input logic [COPIES*WIDTH-1:0] dout,
  input logic                    dout_drive,
  input logic [WIDTH-1:0]        held_q
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> held_q == '0);

  a_r2_full_capture: assert property (@(posedge clk) disable iff (rst)
    !cap_en_n |=> held_q == $past(din));

  a_r3_low_hold: assert property (@(posedge clk) disable iff (rst)
    cap_en_n |=> held_q[HOLD_BITS-1:0] == $past(held_q[HOLD_BITS-1:0]));

  a_r3_high_load: assert property (@(posedge clk) disable iff (rst)
    cap_en_n |=> held_q[WIDTH-1:HOLD_BITS] == $past(din[WIDTH-1:HOLD_BITS]));

  a_r4_buffer_pass: assert property (@(posedge clk) disable iff (rst)
    (mode_buf && !out_en_n) |-> dout[WIDTH-1:0] == din);

  a_r5_register_view: assert property (@(posedge clk) disable iff (rst)
    (!mode_buf && !out_en_n) |-> dout[WIDTH-1:0] == held_q);

  a_r7_released: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> (dout == '0 && !dout_drive));

  a_r7_driving: assert property (@(posedge clk) disable iff (rst)
    !out_en_n |-> dout_drive);

  generate
    for (genvar c = 1; c < COPIES; c++) begin : g_cp
      a_r6_copies_match: assert property (@(posedge clk) disable iff (rst)
        dout[c*WIDTH +: WIDTH] == dout[WIDTH-1:0]);
    end
  endgenerate
endmodule

bind dual_mode_bus_driver bd_driver_checker #(
  .WIDTH(WIDTH), .HOLD_BITS(HOLD_BITS), .COPIES(COPIES)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_buf   (mode_buf),
  .cap_en_n   (cap_en_n),
  .out_en_n   (out_en_n),
  .din        (din),
  .dout       (dout),
  .dout_drive (dout_drive),
  .held_q     (reg_q)
);

// File: tb/dual_mode_bus_driver_tb.sv
`timescale 1ns/1ps
module dual_mode_bus_driver_tb;
  localparam int W = 12;
  localparam int HB = 8;
  localparam int NC = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_buf = 1'b0;
  logic          cap_en_n = 1'b0;
  logic          out_en_n = 1'b0;
  logic [W-1:0]  din = '0;
  logic [NC*W-1:0] dout;
  logic          dout_drive;

  int checks = 0;
  int fails = 0;
  bit started = 0;
  bit done = 0;
  string cur_req = "R1";
  logic [W-1:0] model = '0;

  always #2 clk = ~clk;

  dual_mode_bus_driver #(.WIDTH(W), .HOLD_BITS(HB), .COPIES(NC)) u_dut (
    .clk(clk), .rst(rst), .mode_buf(mode_buf), .cap_en_n(cap_en_n),
    .out_en_n(out_en_n), .din(din), .dout(dout), .dout_drive(dout_drive)
  );

  // reference model of the stored word
  always @(posedge clk) begin
    for (int i = 0; i < W; i++) begin
      if (rst) model[i] <= 1'b0;
      else if (!cap_en_n || i >= HB) model[i] <= din[i];
    end
  end

  task automatic compare(input string req);
    logic [W-1:0] exp_w;
    logic exp_d;
    exp_d = !out_en_n;
    exp_w = out_en_n ? '0 : (mode_buf ? din : model);
    checks++;
    if (dout[W-1:0] !== exp_w || dout_drive !== exp_d) begin
      fails++;
      $display("FAIL %s: copy0=%h drive=%b expected %h drive=%b", req, dout[W-1:0], dout_drive, exp_w, exp_d);
    end
    for (int c = 1; c < NC; c++) begin
      checks++;
      if (dout[c*W +: W] !== dout[W-1:0]) begin
        fails++;
        $display("FAIL R6: copy%0d=%h expected %h", c, dout[c*W +: W], dout[W-1:0]);
      end
    end
  endtask

  always @(negedge clk) if (started && !done) compare(cur_req);

  task automatic step(); @(posedge clk); #1; endtask

  task automatic finish_up();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #20000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected finish");
    finish_up();
  end

  initial begin
    logic [W-1:0] pats [6];
    pats = '{12'hFFF, 12'h000, 12'hA5A, 12'h5A5, 12'h0F0, 12'hC3C};
    // R1: reset clears the register
    cur_req = "R1"; cap_en_n = 1'b0; din = 12'hABC;
    step(); started = 1;
    step(); step();
    rst = 1'b0;
    // R2: full capture in register mode
    cur_req = "R2";
    for (int k = 0; k < 6; k++) begin din = pats[k]; step(); end
    for (int k = 0; k < 10; k++) begin din = W'($urandom); step(); end
    // R3: partial capture, lower group holds
    cur_req = "R3"; din = 12'hFFF; step();
    cap_en_n = 1'b1;
    for (int k = 0; k < 6; k++) begin din = pats[k]; step(); end
    for (int k = 0; k < 10; k++) begin din = W'($urandom); step(); end
    // R4: buffer mode, combinational change mid-cycle
    cur_req = "R4"; mode_buf = 1'b1;
    for (int k = 0; k < 6; k++) begin
      din = pats[k]; #0.3 compare("R4");
      din = ~pats[k]; #0.3 compare("R4");
      step();
    end
    // R5: mode switch within a cycle, registers keep loading
    cur_req = "R5"; cap_en_n = 1'b0;
    for (int k = 0; k < 6; k++) begin
      din = pats[k]; step();
      din = 12'h3C3;
      mode_buf = 1'b0; #0.3 compare("R5");
      mode_buf = 1'b1; #0.3 compare("R5");
    end
    mode_buf = 1'b0; step();
    // R7: release outputs while capturing, then re-enable
    cur_req = "R7"; out_en_n = 1'b1;
    din = 12'h9E1; step();
    cap_en_n = 1'b1;
    for (int k = 0; k < 4; k++) begin din = pats[k]; step(); end
    mode_buf = 1'b1; #0.3 compare("R7"); mode_buf = 1'b0;
    out_en_n = 1'b0; #0.3 compare("R7");
    step(); step();
    // R1: reset wins over capture with non-zero data
    cur_req = "R1"; cap_en_n = 1'b0; din = 12'hFFF; rst = 1'b1;
    step(); step();
    rst = 1'b0; cur_req = "R2"; din = 12'h123; step(); step();
    finish_up();
  end
endmodule